// File: doc/BRIEF.md
# Doorbell Hit-Counting Test Register Block

This block is a small test target on a byte-wide register bus. It is reached through two address windows, a memory-style window and a port-style window, and the bus tells the block which one an access uses. Software picks a test by writing a small selector value to offset 0. The window of that write and the selector value together choose one of six test contexts, and the index is window*3 + selector. Selector 0 is the plain kind, selector 1 is the wildcard kind and selector 2 is the data-match kind. Each context has its own doorbell address and its own match byte.

Once a context is active, the block counts the writes that land on its doorbell address. For the data-match kind, a write also has to be one byte wide and carry the match byte before it counts. Software reads the result back one byte at a time from a 16-byte little-endian header. The header holds the context index, the access width, the doorbell offset, the match byte and a 32-bit hit counter. A driver or a verification program uses the block to confirm that its doorbell writes reach the device and are decoded as expected.

Top module: `dbhit_top`

## Requirements
- R1: After reset no context is active, rdData is 0 and a read of any header byte returns 0.
- R2: A write of a value v < 3 to offset 0 activates context winSel*3+v and clears its hit counter. Header byte 0 then reads back that index.
- R3: A write of a value of 3 or more to offset 0 leaves no context active. After it, reads return 0.
- R4: While no context is active, writes to nonzero offsets do not change state and every read returns 0.
- R5: A write whose address equals the active doorbell offset adds exactly one to the hit counter. A write to any other nonzero address leaves the counter unchanged. The doorbell offset is base + index, with base 2048 for contexts 0 to 2 and base 128 for contexts 3 to 5.
- R6: For the data-match kind (selector 2), a doorbell write counts only if accSize is 1 and wrData is 0xFA. The plain and wildcard kinds count doorbell writes of any data and any size.
- R7: The header layout is fixed. Byte 1 reads 1. Bytes 4 to 7 hold the doorbell offset, least significant byte first. Byte 8 holds the match byte, 0xFA for the data-match kind and 0xCE otherwise. Bytes 2, 3, 9, 10 and 11 read 0.
- R8: Bytes 12 to 15 hold the hit counter, least significant byte first. Any read where addr + accSize >= 16 returns 0, which includes byte 15 at size 1.
- R9: Read data is registered. It appears on rdData after the clock edge that samples rdEn, and rdData holds its value in cycles without rdEn.
- R10: A new write to offset 0 always restarts the selection. Selecting a context again, whether it is the same one or a different one, clears the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| winSel | input | 1 | Window of the access, 0 for memory and 1 for port |
| addr | input | 12 | Byte address within the window |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| accSize | input | 3 | Access size in bytes |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |

## Verification
The assertions assume that wrEn and rdEn are never high in the same cycle. They also assume that port-window addresses stay below 256 and that accSize is never 0. The stimulus issues each access as a single one-cycle strobe that is set up on the falling edge. It keeps addresses inside the window being used and uses only sizes 1 and 2. Reads go out only after the preceding write has been accepted, so the values read back never depend on a write happening at the same edge.

// File: rtl/dbhit_pkg.sv
package dbhit_pkg;
  localparam int KINDS    = 3;
  localparam int WINDOWS  = 2;
  localparam int CTX_N    = KINDS * WINDOWS;
  localparam int CTX_W    = $clog2(CTX_N);
  localparam int HDR_LEN  = 16;
  localparam int OFF_W    = 32;
  localparam int MATCH_KIND = 2;
  localparam logic [7:0] MATCH_YES = 8'hFA;
  localparam logic [7:0] MATCH_NO  = 8'hCE;

  typedef struct packed {
    logic              active;
    logic              clrCnt;
    logic              incCnt;
    logic [CTX_W-1:0]  ctxIdx;
    logic [OFF_W-1:0]  doorbell;
    logic [7:0]        matchByte;
  } dbStrobes_t;
endpackage

// File: rtl/dbhit_ctrl.sv
module dbhit_ctrl
  import dbhit_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int MEM_BASE  = 2048,
  parameter int PORT_BASE = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              winSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic [2:0]        accSize,
  output dbStrobes_t        strobes
);
  logic             active;
  logic [CTX_W-1:0] ctxIdx;
  logic             selWr;
  logic             selOk;
  logic [CTX_W-1:0] nextIdx;
  logic             ctxPort;
  logic [CTX_W-1:0] ctxKind;
  logic [OFF_W-1:0] doorbell;
  logic             needMatch;
  logic             dataOk;
  logic             hit;

  assign selWr   = wrEn && (addr == '0);
  assign selOk   = (wrData < 8'(KINDS));
  assign nextIdx = CTX_W'(winSel) * CTX_W'(KINDS) + CTX_W'(wrData[1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      ctxIdx <= '0;
    end else if (selWr) begin
      active <= selOk;
      if (selOk) ctxIdx <= nextIdx;
    end
  end

  assign ctxPort   = (ctxIdx >= CTX_W'(KINDS));
  assign ctxKind   = ctxPort ? ctxIdx - CTX_W'(KINDS) : ctxIdx;
  assign doorbell  = (ctxPort ? OFF_W'(PORT_BASE) : OFF_W'(MEM_BASE)) + OFF_W'(ctxIdx);
  assign needMatch = (ctxKind == CTX_W'(MATCH_KIND));
  assign dataOk    = !needMatch || ((accSize == 3'd1) && (wrData == MATCH_YES));
  assign hit       = wrEn && !selWr && active &&
                     (OFF_W'(addr) == doorbell) && dataOk;

  always_comb begin
    strobes.active    = active;
    strobes.clrCnt    = selWr && selOk;
    strobes.incCnt    = hit;
    strobes.ctxIdx    = ctxIdx;
    strobes.doorbell  = doorbell;
    strobes.matchByte = needMatch ? MATCH_YES : MATCH_NO;
  end

  AST_BAD_SEL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (selWr && !selOk) |=> !active); // R3
  AST_SEL_ACTIVATES: assert property (@(posedge clk) disable iff (!rstN)
    (selWr && selOk) |=> (active && ctxIdx == $past(nextIdx))); // R2
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !strobes.incCnt); // R4
  AST_SEL_BEATS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    selWr |-> !strobes.incCnt); // R10
endmodule

// File: rtl/dbhit_datapath.sv
module dbhit_datapath
  import dbhit_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        accSize,
  input  logic              rdEn,
  input  dbStrobes_t        strobes,
  output logic [7:0]        rdData
);
  localparam int CNT_BYTES = CNT_W / 8;
  localparam int CNT_POS   = 12;
  localparam int OFF_POS   = 4;
  localparam int SUM_W     = ADDR_W + 1;

  logic [CNT_W-1:0] hitCnt;
  logic [7:0]       hdr [HDR_LEN];
  logic [SUM_W-1:0] endAddr;
  logic             inRange;
  logic [7:0]       rdByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                hitCnt <= '0;
    else if (strobes.clrCnt)  hitCnt <= '0;
    else if (strobes.incCnt)  hitCnt <= hitCnt + 1'b1;
  end

  always_comb begin
    for (int b = 0; b < HDR_LEN; b++) hdr[b] = 8'h00;
    hdr[0] = 8'(strobes.ctxIdx);
    hdr[1] = 8'd1;
    for (int b = 0; b < OFF_W / 8; b++) hdr[OFF_POS + b] = strobes.doorbell[8*b +: 8];
    hdr[8] = strobes.matchByte;
    for (int b = 0; b < CNT_BYTES; b++) hdr[CNT_POS + b] = hitCnt[8*b +: 8];
  end

  assign endAddr = SUM_W'(addr) + SUM_W'(accSize);
  assign inRange = (endAddr < SUM_W'(HDR_LEN));
  assign rdByte  = (strobes.active && inRange) ? hdr[addr[3:0]] : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= 8'h00;
    else if (rdEn) rdData <= rdByte;
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrCnt |=> (hitCnt == '0)); // R10
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incCnt && !strobes.clrCnt) |=> (hitCnt == $past(hitCnt) + 1'b1)); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.incCnt && !strobes.clrCnt) |=> $stable(hitCnt)); // R6
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !strobes.active) |=> (rdData == 8'h00)); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R9
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !inRange) |=> (rdData == 8'h00)); // R8
endmodule

// File: rtl/dbhit_top.sv
module dbhit_top
  import dbhit_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CNT_W     = 32,
  parameter int MEM_BASE  = 2048,
  parameter int PORT_BASE = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              winSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic [2:0]        accSize,
  input  logic              rdEn,
  output logic [7:0]        rdData
);
  dbStrobes_t strobes;

  dbhit_ctrl #(
    .ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE), .PORT_BASE(PORT_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .winSel(winSel), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .accSize(accSize), .strobes(strobes)
  );

  dbhit_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .accSize(accSize), .rdEn(rdEn),
    .strobes(strobes), .rdData(rdData)
  );
endmodule

// File: tb/dbhit_top_tb.sv
module dbhit_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 43;

  typedef struct packed {
    logic        isRd;
    logic        win;
    logic [11:0] addr;
    logic [7:0]  data;
    logic [2:0]  size;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 12'd0,    8'd1,   3'd1, 8'h00, 4'd2},  // R2 select mem wildcard, idx 1
    '{1'b1, 1'b0, 12'd0,    8'd0,   3'd1, 8'h01, 4'd2},  // R2
    '{1'b1, 1'b0, 12'd1,    8'd0,   3'd1, 8'h01, 4'd7},  // R7
    '{1'b1, 1'b0, 12'd4,    8'd0,   3'd1, 8'h01, 4'd7},  // R7 doorbell 2049
    '{1'b1, 1'b0, 12'd5,    8'd0,   3'd1, 8'h08, 4'd7},  // R7
    '{1'b1, 1'b0, 12'd8,    8'd0,   3'd1, 8'hCE, 4'd7},  // R7
    '{1'b1, 1'b0, 12'd2,    8'd0,   3'd1, 8'h00, 4'd7},  // R7 pad
    '{1'b1, 1'b0, 12'd12,   8'd0,   3'd1, 8'h00, 4'd2},  // R2 cleared
    '{1'b0, 1'b0, 12'd2049, 8'h33,  3'd1, 8'h00, 4'd5},  // R5 hit
    '{1'b0, 1'b0, 12'd2049, 8'h00,  3'd2, 8'h00, 4'd6},  // R6 wildcard any size
    '{1'b0, 1'b0, 12'd2050, 8'hFA,  3'd1, 8'h00, 4'd5},  // R5 miss
    '{1'b1, 1'b0, 12'd12,   8'd0,   3'd1, 8'h02, 4'd5},  // R5
    '{1'b0, 1'b0, 12'd0,    8'd2,   3'd1, 8'h00, 4'd6},  // R6 select mem match, idx 2
    '{1'b0, 1'b0, 12'd2050, 8'hFA,  3'd1, 8'h00, 4'd6},  // R6 hit
    '{1'b0, 1'b0, 12'd2050, 8'hFB,  3'd1, 8'h00, 4'd6},  // R6 wrong data
    '{1'b0, 1'b0, 12'd2050, 8'hFA,  3'd2, 8'h00, 4'd6},  // R6 wrong size
    '{1'b0, 1'b0, 12'd2049, 8'hFA,  3'd1, 8'h00, 4'd5},  // R5 wrong addr
    '{1'b1, 1'b0, 12'd12,   8'd0,   3'd1, 8'h01, 4'd6},  // R6
    '{1'b1, 1'b0, 12'd8,    8'd0,   3'd1, 8'hFA, 4'd7},  // R7
    '{1'b1, 1'b0, 12'd0,    8'd0,   3'd1, 8'h02, 4'd2},  // R2
    '{1'b0, 1'b1, 12'd0,    8'd0,   3'd1, 8'h00, 4'd10}, // R10 port plain, idx 3
    '{1'b1, 1'b1, 12'd12,   8'd0,   3'd1, 8'h00, 4'd10}, // R10
    '{1'b1, 1'b1, 12'd0,    8'd0,   3'd1, 8'h03, 4'd2},  // R2
    '{1'b1, 1'b1, 12'd4,    8'd0,   3'd1, 8'h83, 4'd7},  // R7 doorbell 131
    '{1'b1, 1'b1, 12'd5,    8'd0,   3'd1, 8'h00, 4'd7},  // R7
    '{1'b0, 1'b1, 12'd131,  8'h77,  3'd2, 8'h00, 4'd6},  // R6 plain any size
    '{1'b0, 1'b1, 12'd131,  8'h11,  3'd1, 8'h00, 4'd5},  // R5
    '{1'b1, 1'b1, 12'd12,   8'd0,   3'd1, 8'h02, 4'd5},  // R5
    '{1'b0, 1'b1, 12'd0,    8'd0,   3'd1, 8'h00, 4'd10}, // R10 reselect
    '{1'b1, 1'b1, 12'd12,   8'd0,   3'd1, 8'h00, 4'd10}, // R10
    '{1'b0, 1'b1, 12'd0,    8'd5,   3'd1, 8'h00, 4'd3},  // R3 bad selector
    '{1'b1, 1'b1, 12'd0,    8'd0,   3'd1, 8'h00, 4'd3},  // R3
    '{1'b1, 1'b1, 12'd1,    8'd0,   3'd1, 8'h00, 4'd4},  // R4
    '{1'b0, 1'b1, 12'd131,  8'h11,  3'd1, 8'h00, 4'd4},  // R4 ignored
    '{1'b1, 1'b1, 12'd8,    8'd0,   3'd1, 8'h00, 4'd4},  // R4
    '{1'b0, 1'b1, 12'd0,    8'd2,   3'd1, 8'h00, 4'd2},  // R2 port match, idx 5
    '{1'b0, 1'b1, 12'd133,  8'hFA,  3'd1, 8'h00, 4'd6},  // R6
    '{1'b1, 1'b1, 12'd12,   8'd0,   3'd1, 8'h01, 4'd8},  // R8
    '{1'b1, 1'b1, 12'd13,   8'd0,   3'd1, 8'h00, 4'd8},  // R8
    '{1'b1, 1'b1, 12'd14,   8'd0,   3'd1, 8'h00, 4'd8},  // R8
    '{1'b1, 1'b1, 12'd15,   8'd0,   3'd1, 8'h00, 4'd8},  // R8 tail
    '{1'b1, 1'b1, 12'd14,   8'd0,   3'd2, 8'h00, 4'd8},  // R8 tail
    '{1'b1, 1'b1, 12'd0,    8'd0,   3'd1, 8'h05, 4'd2}   // R2
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        winSel = 1'b0;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [2:0]  accSize = 3'd1;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dbhit_top u_dut (
    .clk(clk), .rstN(rstN), .winSel(winSel), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .accSize(accSize), .rdEn(rdEn), .rdData(rdData)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic w, input logic [11:0] a, input logic [7:0] d,
                         input logic [2:0] s);
    @(negedge clk);
    winSel = w; addr = a; wrData = d; accSize = s; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic w, input logic [11:0] a, input logic [2:0] s,
                        input logic [7:0] exp, input string req);
    @(negedge clk);
    winSel = w; addr = a; accSize = s; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(rdData, exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rdData, 8'h00, "R1");
    rstN = 1'b1;
    doRead(1'b0, 12'd0, 3'd1, 8'h00, "R1");
    doRead(1'b0, 12'd1, 3'd1, 8'h00, "R1");

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isRd)
        doRead(VECS[i].win, VECS[i].addr, VECS[i].size, VECS[i].exp,
               $sformatf("R%0d vec%0d", VECS[i].req, i));
      else
        doWrite(VECS[i].win, VECS[i].addr, VECS[i].data, VECS[i].size);
    end

    // R5 R8: 256 hits on port wildcard (idx 4, doorbell 132) carry into byte 13
    doWrite(1'b1, 12'd0, 8'd1, 3'd1);
    for (int k = 0; k < 256; k++) doWrite(1'b1, 12'd132, 8'(k), 3'd1);
    doRead(1'b1, 12'd12, 3'd1, 8'h00, "R8 byte12");
    doRead(1'b1, 12'd13, 3'd1, 8'h01, "R8 byte13");

    // R9: value held while rdEn low
    doRead(1'b1, 12'd0, 3'd1, 8'h04, "R9");
    repeat (3) @(negedge clk);
    check(rdData, 8'h04, "R9 hold");

    // R1: reset mid-test deactivates
    rstN = 1'b0;
    @(negedge clk);
    check(rdData, 8'h00, "R1 reset");
    rstN = 1'b1;
    doRead(1'b1, 12'd0, 3'd1, 8'h00, "R1 idle after reset");
    doRead(1'b1, 12'd1, 3'd1, 8'h00, "R1 idle after reset");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule